// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

This block is a small programmable AND-OR array of the kind found in classic programmable logic. Every source signal feeds two array lines, its true value and its complement. Each product term is the AND of the lines whose configuration fuse is intact. Each output is the OR of a fixed, contiguous group of product terms. The output is combinational from the sources. The surrounding macrocell handles registering, tri-state driving and routing of the outputs.

The fuse map arrives as a serial bit stream into a shadow register. A small configuration state machine copies the shadow into the active map only after a load strobe, so the array never evaluates a partly shifted map. The machine has three states. `CFG_IDLE` waits. A shift moves it to `CFG_FILL` and a load moves it to `CFG_COMMIT`. `CFG_FILL` collects bits and leaves for `CFG_COMMIT` on a load. `CFG_COMMIT` writes the active map for one cycle and then returns to `CFG_IDLE`, or stays in `CFG_COMMIT` if another load is present.

When the `USE_FB` parameter is set, the output feedback signals join the array as extra sources after the primary inputs. When it is clear, the feedback lines are held disconnected.

Top module: `pterm_array`

## Requirements
- R1: Array lines are numbered from 0. Source i drives line 2i with its true value and line 2i+1 with its complement. Primary inputs come first, as sources 0 to N_IN-1.
- R2: A fuse value of 0 connects its line to the product term. A value of 1 removes the line. A product term is the AND of all of its connected lines.
- R3: A product term with every fuse at 1 contributes 0 to its OR. After reset every fuse reads 1, so every output is 0.
- R4: Output o is the OR of product terms o*N_PT to o*N_PT+N_PT-1 and of no other terms.
- R5: A product term that connects both the true and the complement line of the same source always evaluates to 0.
- R6: Each cycle with cfg_shift high shifts cfg_data into the shadow map. After N_OUT*N_PT*L shifts, where L is the number of array lines, shifted bit k (counted from 0) is the fuse of product term k/L, line k%L.
- R7: The array uses only the active map. Shifting alone leaves the outputs unchanged. A cfg_load seen at a clock edge makes the outputs follow the shadow map from the next clock edge on.
- R8: The state machine goes to CFG_COMMIT on any cfg_load, and goes from CFG_IDLE to CFG_FILL on a shift that has no load. A load with no new shifts applies the shadow map again unchanged.
- R9: With USE_FB=1, feedback bit j is source N_IN+j and has its own true and complement lines. With USE_FB=0, fb_in has no effect on the outputs.
- R10: For any fuse map the outputs equal the sum-of-products that R1 to R5 define.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Active-low reset. Blows every fuse in both maps |
| cfg_shift | input | 1 | Shift enable for the serial fuse stream |
| cfg_data | input | 1 | Serial fuse bit, first bit goes to term 0 line 0 |
| cfg_load | input | 1 | Strobe that copies the shadow map into the active map |
| in_pins | input | N_IN | Primary array sources |
| fb_in | input | N_OUT | Output feedback sources, used when USE_FB=1 |
| sum_out | output | N_OUT | OR of each output's product terms |

## Verification
The bench targets these corner cases:

- **All-blown terms.** The bench checks that a term with every fuse blown is suppressed. A design that simply ANDed the lines would drive its output to 1.
- **Contradictory terms.** A term that connects both polarities of one input must read 0. The bench also connects every line of a term at once.
- **Line and stream order.** A single intact fuse in the last bit of the stream shows whether the line order or the shift direction is swapped. A swap moves that term to a different output or input.
- **Shift without load.** A map is shifted but not loaded, and the outputs must not move. A design that reads the shadow map directly would change its outputs during the shift.
- **Feedback handling.** Feedback must be ignored when USE_FB=0 and used with the right polarity when USE_FB=1.

Random maps are compared with a software model.

// File: rtl/pta_pkg.sv
`timescale 1ns/1ps
package pta_pkg;
    typedef enum logic [1:0] {
        CFG_IDLE   = 2'd0,
        CFG_FILL   = 2'd1,
        CFG_COMMIT = 2'd2
    } cfg_state_e;
endpackage

// File: rtl/pta_cfg_loader.sv
`timescale 1ns/1ps
module pta_cfg_loader #(
    parameter int NF = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shift_i,
    input  logic          data_i,
    input  logic          load_i,
    output logic [NF-1:0] map_o
);
    import pta_pkg::*;

    cfg_state_e    state_q, state_d;
    logic          commit_en;
    logic [NF-1:0] shadow_q;
    logic [NF-1:0] active_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CFG_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CFG_IDLE: begin
                if (load_i)       state_d = CFG_COMMIT;
                else if (shift_i) state_d = CFG_FILL;
            end
            CFG_FILL: begin
                if (load_i) state_d = CFG_COMMIT;
            end
            CFG_COMMIT: begin
                if (load_i) state_d = CFG_COMMIT;
                else        state_d = CFG_IDLE;
            end
            default: state_d = CFG_IDLE;
        endcase
    end

    // state outputs
    always_comb begin
        commit_en = (state_q == CFG_COMMIT);
    end

    // serial shadow map, first bit ends in the MSB
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       shadow_q <= '1;
        else if (shift_i) shadow_q <= {shadow_q[NF-2:0], data_i};
    end

    // active map seen by the array
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         active_q <= '1;
        else if (commit_en) active_q <= shadow_q;
    end

    assign map_o = active_q;
endmodule

// File: rtl/pta_and_plane.sv
`timescale 1ns/1ps
module pta_and_plane #(
    parameter int NL = 4,
    parameter int NT = 8
) (
    input  logic [NL-1:0]    lines_i,
    input  logic [NT*NL-1:0] fuses_i,
    output logic [NT-1:0]    terms_o
);
    for (genvar t = 0; t < NT; t++) begin : g_term
        logic [NL-1:0] row;
        logic          all_lines_true;
        logic          row_empty;
        assign row            = fuses_i[t*NL +: NL];
        assign all_lines_true = &(lines_i | row);
        assign row_empty      = &row;
        assign terms_o[t]     = all_lines_true & ~row_empty;
    end
endmodule

// File: rtl/pta_or_plane.sv
`timescale 1ns/1ps
module pta_or_plane #(
    parameter int NO  = 2,
    parameter int NPT = 4
) (
    input  logic [NO*NPT-1:0] terms_i,
    output logic [NO-1:0]     sum_o
);
    for (genvar o = 0; o < NO; o++) begin : g_sum
        assign sum_o[o] = |terms_i[o*NPT +: NPT];
    end
endmodule

// File: rtl/pterm_array.sv
`timescale 1ns/1ps
module pterm_array #(
    parameter int N_IN   = 2,
    parameter int N_OUT  = 2,
    parameter int N_PT   = 4,
    parameter bit USE_FB = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_shift,
    input  logic             cfg_data,
    input  logic             cfg_load,
    input  logic [N_IN-1:0]  in_pins,
    input  logic [N_OUT-1:0] fb_in,
    output logic [N_OUT-1:0] sum_out
);
    localparam int N_SRC_ALL = N_IN + N_OUT;
    localparam int NL_ALL    = 2 * N_SRC_ALL;
    localparam int N_SRC_MAP = USE_FB ? N_SRC_ALL : N_IN;
    localparam int NL_MAP    = 2 * N_SRC_MAP;
    localparam int N_TERMS   = N_OUT * N_PT;
    localparam int NF        = N_TERMS * NL_MAP;

    logic [NF-1:0]             stream_map;
    logic [NF-1:0]             nat_map;
    logic [N_TERMS*NL_ALL-1:0] full_map;
    logic [N_SRC_ALL-1:0]      src;
    logic [NL_ALL-1:0]         lines;
    logic [N_TERMS-1:0]        terms;

    pta_cfg_loader #(.NF(NF)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_i (cfg_shift),
        .data_i  (cfg_data),
        .load_i  (cfg_load),
        .map_o   (stream_map)
    );

    // stream bit k (first shifted = MSB) becomes natural index k
    for (genvar j = 0; j < NF; j++) begin : g_rev
        assign nat_map[j] = stream_map[NF-1-j];
    end

    // widen each row to every line; absent feedback lines stay blown
    for (genvar t = 0; t < N_TERMS; t++) begin : g_row
        if (USE_FB) begin : g_fb
            assign full_map[t*NL_ALL +: NL_ALL] = nat_map[t*NL_MAP +: NL_MAP];
        end else begin : g_nofb
            assign full_map[t*NL_ALL +: NL_ALL] =
                {{(NL_ALL-NL_MAP){1'b1}}, nat_map[t*NL_MAP +: NL_MAP]};
        end
    end

    assign src = {fb_in, in_pins};

    for (genvar i = 0; i < N_SRC_ALL; i++) begin : g_line
        assign lines[2*i]   = src[i];
        assign lines[2*i+1] = ~src[i];
    end

    pta_and_plane #(.NL(NL_ALL), .NT(N_TERMS)) u_and (
        .lines_i (lines),
        .fuses_i (full_map),
        .terms_o (terms)
    );

    pta_or_plane #(.NO(N_OUT), .NPT(N_PT)) u_or (
        .terms_i (terms),
        .sum_o   (sum_out)
    );
endmodule

// File: rtl/pta_checker.sv
`timescale 1ns/1ps
module pta_checker #(
    parameter int NF    = 32,
    parameter int N_OUT = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_shift,
    input logic                cfg_data,
    input logic                cfg_load,
    input logic [N_OUT-1:0]    sum_out,
    input pta_pkg::cfg_state_e st,
    input logic [NF-1:0]       shadow,
    input logic [NF-1:0]       active
);
    import pta_pkg::*;

    p_blank_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (&active) |-> (sum_out == '0));

    p_shift_in_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_shift |=> (shadow[0] == $past(cfg_data)));

    p_hold_map_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st != CFG_COMMIT) |=> $stable(active));

    p_commit_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CFG_COMMIT) |=> (active == $past(shadow)));

    p_load_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> (st == CFG_COMMIT));

    p_idle_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CFG_IDLE && cfg_shift && !cfg_load) |=> (st == CFG_FILL));
endmodule

bind pterm_array pta_checker #(.NF(NF), .N_OUT(N_OUT)) u_pta_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_shift (cfg_shift),
    .cfg_data  (cfg_data),
    .cfg_load  (cfg_load),
    .sum_out   (sum_out),
    .st        (u_cfg.state_q),
    .shadow    (u_cfg.shadow_q),
    .active    (u_cfg.active_q)
);

// File: tb/test_pterm_array.sv
`timescale 1ns/1ps
module test_pterm_array;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst_n;
    logic       sh_a, d_a, ld_a, sh_b, d_b, ld_b;
    logic [1:0] in_a, fb_a, in_b, fb_b;
    logic [1:0] out_a, out_b;

    int checks = 0;
    int errors = 0;
    bit fz  [8][4];   // main DUT: 8 terms x 4 lines
    bit fzb [4][8];   // feedback DUT: 4 terms x 8 lines

    pterm_array i_pterm_array (
        .clk(clk), .rst_n(rst_n), .cfg_shift(sh_a), .cfg_data(d_a),
        .cfg_load(ld_a), .in_pins(in_a), .fb_in(fb_a), .sum_out(out_a));

    pterm_array #(.N_IN(2), .N_OUT(2), .N_PT(2), .USE_FB(1'b1)) i_pterm_array_fb (
        .clk(clk), .rst_n(rst_n), .cfg_shift(sh_b), .cfg_data(d_b),
        .cfg_load(ld_b), .in_pins(in_b), .fb_in(fb_b), .sum_out(out_b));

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    function automatic logic [1:0] model(input logic a, input logic b);
        logic [1:0] r = 2'b00;
        logic [3:0] v = {~b, b, ~a, a};
        for (int t = 0; t < 8; t++) begin
            bit any = 0;
            bit ok  = 1;
            for (int l = 0; l < 4; l++)
                if (!fz[t][l]) begin any = 1; if (!v[l]) ok = 0; end
            if (any && ok) r[t/4] = 1'b1;
        end
        return r;
    endfunction

    task automatic set_all(input bit v);
        for (int t = 0; t < 8; t++) for (int l = 0; l < 4; l++) fz[t][l] = v;
    endtask

    task automatic shift_main();
        for (int t = 0; t < 8; t++)
            for (int l = 0; l < 4; l++) begin
                @(negedge clk); sh_a = 1'b1; d_a = fz[t][l];
            end
        @(negedge clk); sh_a = 1'b0;
    endtask

    task automatic load_main();
        @(negedge clk); ld_a = 1'b1;
        @(negedge clk); ld_a = 1'b0;
        @(negedge clk);
    endtask

    task automatic sweep(input string req);
        for (int v = 0; v < 4; v++) begin
            @(negedge clk); in_a = 2'(v);
            #1 check(req, out_a, model(in_a[0], in_a[1]));
        end
    endtask

    task automatic t_reset();
        for (int v = 0; v < 4; v++) begin
            @(negedge clk); in_a = 2'(v); in_b = 2'(v);
            #1 check("R3 reset", out_a, 2'b00);
            check("R3 reset fb", out_b, 2'b00);
        end
    endtask

    task automatic t_example();
        set_all(1);
        fz[0][0] = 0; fz[0][2] = 0;   // A*B
        fz[1][1] = 0; fz[1][2] = 0;   // /A*B
        fz[4][0] = 0; fz[4][3] = 0;   // A*/B
        shift_main(); load_main();
        for (int v = 0; v < 4; v++) begin
            @(negedge clk); in_a = 2'(v);
            // R1 R2 R4: X = B, Y = A & ~B
            #1 check("R1 R2 R4 example", out_a, {in_a[0] & ~in_a[1], in_a[1]});
        end
    endtask

    task automatic t_no_load();
        set_all(1);
        fz[0][0] = 0; fz[4][0] = 0;    // both outputs = A
        shift_main();
        @(negedge clk); in_a = 2'b01;  // A=1 B=0
        #1 check("R7 shift only", out_a, 2'b10);
        load_main();
        @(negedge clk);
        #1 check("R7 after load", out_a, 2'b11);
    endtask

    task automatic t_reload();
        load_main();                   // R8: no new shifts, same map
        sweep("R8 reload");
    endtask

    task automatic t_contradiction();
        set_all(1);
        fz[0][0] = 0; fz[0][1] = 0;    // A*/A
        for (int l = 0; l < 4; l++) fz[4][l] = 0;  // every line
        shift_main(); load_main();
        for (int v = 0; v < 4; v++) begin
            @(negedge clk); in_a = 2'(v);
            #1 check("R5 contradiction", out_a, 2'b00);
        end
    endtask

    task automatic t_all_blown();
        set_all(1);
        shift_main(); load_main();
        for (int v = 0; v < 4; v++) begin
            @(negedge clk); in_a = 2'(v);
            #1 check("R3 all blown", out_a, 2'b00);
        end
    endtask

    task automatic t_last_fuse();
        set_all(1);
        fz[7][3] = 0;                  // last stream bit: term 7, /B
        shift_main(); load_main();
        for (int v = 0; v < 4; v++) begin
            @(negedge clk); in_a = 2'(v);
            #1 check("R6 last fuse", out_a, {~in_a[1], 1'b0});
        end
    endtask

    task automatic t_random();
        for (int n = 0; n < 24; n++) begin
            for (int t = 0; t < 8; t++)
                for (int l = 0; l < 4; l++) fz[t][l] = ($urandom_range(0, 2) != 0);
            shift_main(); load_main();
            sweep("R10 random");
        end
    endtask

    task automatic t_fb_ignored();
        set_all(1);
        fz[0][0] = 0; fz[0][2] = 0; fz[5][1] = 0;
        shift_main(); load_main();
        for (int v = 0; v < 16; v++) begin
            @(negedge clk); in_a = 2'(v); fb_a = 2'(v >> 2);
            #1 check("R9 fb ignored", out_a, model(in_a[0], in_a[1]));
        end
    endtask

    task automatic t_feedback();
        for (int t = 0; t < 4; t++) for (int l = 0; l < 8; l++) fzb[t][l] = 1;
        fzb[0][0] = 0; fzb[0][4] = 0;  // A * fb0
        fzb[2][7] = 0;                 // /fb1
        for (int t = 0; t < 4; t++)
            for (int l = 0; l < 8; l++) begin
                @(negedge clk); sh_b = 1'b1; d_b = fzb[t][l];
            end
        @(negedge clk); sh_b = 1'b0; ld_b = 1'b1;
        @(negedge clk); ld_b = 1'b0;
        @(negedge clk);
        for (int v = 0; v < 16; v++) begin
            @(negedge clk); in_b = 2'(v); fb_b = 2'(v >> 2);
            #1 check("R9 feedback", out_b, {~fb_b[1], in_b[0] & fb_b[0]});
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        sh_a = 0; d_a = 0; ld_a = 0; in_a = 0; fb_a = 0;
        sh_b = 0; d_b = 0; ld_b = 0; in_b = 0; fb_b = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_example();
        t_no_load();
        t_reload();
        t_contradiction();
        t_all_blown();
        t_last_fuse();
        t_random();
        t_fb_ignored();
        t_feedback();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule